// File: doc/BRIEF.md
# Subvector Transpose Index Sequencer

This block produces the stream of source and destination element offsets for a vectorised move in which each vector element is itself a small subvector of one to four sub-elements. A move is described by a vector length and a subvector length; the sequencer steps through every (element, sub-element) pair in a fixed nested order, with the element index as the outer loop and the sub-element index as the inner loop, and emits one source/destination offset pair per step.

Each side (source and destination) maps the current pair to a register offset in one of two ways. The plain mapping gives `i*SUB + j`, which visits offsets in natural order. The transposed mapping gives `j*VL + i`, which gathers all sub-elements of the same index together. A pack flag selects the transposed mapping for the source side, and an unpack flag does the same for the destination side. The flags are independent; with both set, both sides walk the same transposed order. The result is a transpose of subvector elements between the two register ranges.

A consumer raises a start pulse with the configuration, then takes pairs by asserting an advance strobe while a pair is valid. After the last pair the done flag rises and stays until the next start.

Top module: `subvec_xpose_seq`

## Requirements
- R1: After reset, and until the first start, pairValid and seqDone are both low.
- R2: A start pulse latches vecLen, subLenCode, packEn and unpackEn; when vecLen is non-zero, in the cycle after start pairValid is high and both offsets are 0.
- R3: With packEn low, the source offset for step (i, j) is i*SUB+j, so the source visits 0, 1, ..., VL*SUB-1 in order; the same holds for the destination with unpackEn low.
- R4: With packEn high the source offset for step (i, j) is j*VL+i; for VL=3, SUB=2 the source visits 0,3,1,4,2,5 while the destination visits 0..5.
- R5: With unpackEn high and packEn low the destination takes the transposed offsets j*VL+i and the source stays in natural order.
- R6: With both flags high both offsets equal j*VL+i at every step.
- R7: While a pair is valid and advance is low (and no start), the pair and its offsets are held unchanged.
- R8: Exactly VL*SUB pairs are accepted; in the cycle after the last accepted pair, pairValid falls and seqDone rises, and seqDone stays high until the next start. pairValid and seqDone are never high together.
- R9: A start with vecLen equal to 0 yields no pair: in the next cycle seqDone is high and pairValid is low.
- R10: With SUB=1 both mappings give the plain count 0..VL-1, so source and destination offsets are equal.
- R11: A start in the middle of a sequence (also when advance is high in the same cycle) discards the current sequence and restarts at step (0, 0) with the new configuration.
- R12: subLenCode encodes the subvector length as code+1: 0 means 1, 1 means 2, 2 means 3, 3 means 4.
- R13: Changes on vecLen, subLenCode, packEn and unpackEn outside a start cycle have no effect on the offsets or on the sequence length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new sequence with the configuration on the inputs |
| vecLen | input | VL_W | Number of vector elements (VL), 0 allowed |
| subLenCode | input | 2 | Subvector length minus one |
| packEn | input | 1 | Source side uses the transposed mapping |
| unpackEn | input | 1 | Destination side uses the transposed mapping |
| advance | input | 1 | Consumer takes the current pair |
| srcOfs | output | VL_W+2 | Source element offset of the current pair |
| dstOfs | output | VL_W+2 | Destination element offset of the current pair |
| pairValid | output | 1 | srcOfs and dstOfs hold a pair to be taken |
| seqDone | output | 1 | All pairs of the sequence have been taken |

## Verification
The move is tried with each of the four flag combinations so that a swapped mapping on one side, or the same mapping on both, shows up as a mismatch, and the fixed VL=3, SUB=2 case is compared against the literal order 0,3,1,4,2,5 to separate a true transpose from a plain count. Subvector lengths 1 through 4 exercise every code value, with length 1 separating the two mappings from each other only where they should coincide. Continuous, gapped and random advance patterns tell holding apart from stepping, while an empty vector, a restart during a run and configuration changes after start probe the sequence boundaries and the latching.

// File: rtl/subvec_seq_pkg.sv
package subvec_seq_pkg;

  // Strobes from the control FSM to the index datapath
  typedef struct packed {
    logic load;       // latch configuration and clear both loop indices
    logic stepInner;  // advance the sub-element index
    logic stepOuter;  // wrap the sub-element index, advance the element index
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;

  localparam int SUB_CODE_W = 2;

endpackage

// File: rtl/subvec_seq_ctrl.sv
module subvec_seq_ctrl
  import subvec_seq_pkg::*;
#(
  parameter int VL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vecLen,
  input  logic            advance,
  input  logic            innerLast,
  input  logic            outerLast,
  output seqStrobe_t      strobe,
  output logic            pairValid,
  output logic            seqDone
);

  seqState_t stateQ, stateD;
  logic      vlEmpty;

  assign vlEmpty = (vecLen == '0);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (start) begin
      strobe.load = 1'b1;
      stateD      = vlEmpty ? SEQ_DONE : SEQ_RUN;
    end else if (stateQ == SEQ_RUN && advance) begin
      if (innerLast && outerLast) begin
        stateD = SEQ_DONE;
      end else if (innerLast) begin
        strobe.stepOuter = 1'b1;
      end else begin
        strobe.stepInner = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= SEQ_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign pairValid = (stateQ == SEQ_RUN);
  assign seqDone   = (stateQ == SEQ_DONE);

endmodule

// File: rtl/subvec_seq_dp.sv
module subvec_seq_dp
  import subvec_seq_pkg::*;
#(
  parameter int VL_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  seqStrobe_t              strobe,
  input  logic [VL_W-1:0]         vecLen,
  input  logic [SUB_CODE_W-1:0]   subLenCode,
  input  logic                    packEn,
  input  logic                    unpackEn,
  output logic [VL_W+1:0]         srcOfs,
  output logic [VL_W+1:0]         dstOfs,
  output logic                    innerLast,
  output logic                    outerLast
);

  localparam int OFS_W = VL_W + 2;

  logic [VL_W-1:0]       vlQ;
  logic [SUB_CODE_W-1:0] subMaxQ;
  logic                  packQ, unpackQ;
  logic [VL_W-1:0]       elemQ;
  logic [SUB_CODE_W-1:0] subQ;
  logic [OFS_W-1:0]      linOfsQ;   // i*SUB + j, kept as a running count
  logic [OFS_W-1:0]      trOfsQ;    // j*VL + i, kept by stride addition

  logic [OFS_W-1:0] vlStride;
  logic [OFS_W-1:0] nextElemBase;

  assign vlStride     = OFS_W'(vlQ);
  assign nextElemBase = OFS_W'(elemQ) + OFS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlQ     <= '0;
      subMaxQ <= '0;
      packQ   <= 1'b0;
      unpackQ <= 1'b0;
    end else if (strobe.load) begin
      vlQ     <= vecLen;
      subMaxQ <= subLenCode;
      packQ   <= packEn;
      unpackQ <= unpackEn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elemQ   <= '0;
      subQ    <= '0;
      linOfsQ <= '0;
      trOfsQ  <= '0;
    end else if (strobe.load) begin
      elemQ   <= '0;
      subQ    <= '0;
      linOfsQ <= '0;
      trOfsQ  <= '0;
    end else if (strobe.stepOuter) begin
      elemQ   <= elemQ + VL_W'(1);
      subQ    <= '0;
      linOfsQ <= linOfsQ + OFS_W'(1);
      trOfsQ  <= nextElemBase;
    end else if (strobe.stepInner) begin
      subQ    <= subQ + SUB_CODE_W'(1);
      linOfsQ <= linOfsQ + OFS_W'(1);
      trOfsQ  <= trOfsQ + vlStride;
    end
  end

  assign innerLast = (subQ == subMaxQ);
  assign outerLast = (elemQ == vlQ - VL_W'(1));

  assign srcOfs = packQ   ? trOfsQ : linOfsQ;
  assign dstOfs = unpackQ ? trOfsQ : linOfsQ;

endmodule

// File: rtl/subvec_xpose_seq.sv
module subvec_xpose_seq
  import subvec_seq_pkg::*;
#(
  parameter int VL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vecLen,
  input  logic [1:0]      subLenCode,
  input  logic            packEn,
  input  logic            unpackEn,
  input  logic            advance,
  output logic [VL_W+1:0] srcOfs,
  output logic [VL_W+1:0] dstOfs,
  output logic            pairValid,
  output logic            seqDone
);

  seqStrobe_t strobe;
  logic       innerLast, outerLast;

  subvec_seq_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vecLen    (vecLen),
    .advance   (advance),
    .innerLast (innerLast),
    .outerLast (outerLast),
    .strobe    (strobe),
    .pairValid (pairValid),
    .seqDone   (seqDone)
  );

  subvec_seq_dp #(.VL_W(VL_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .vecLen     (vecLen),
    .subLenCode (subLenCode),
    .packEn     (packEn),
    .unpackEn   (unpackEn),
    .srcOfs     (srcOfs),
    .dstOfs     (dstOfs),
    .innerLast  (innerLast),
    .outerLast  (outerLast)
  );

endmodule

// File: rtl/subvec_seq_chk.sv
module subvec_seq_chk #(
  parameter int VL_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VL_W-1:0] vecLen,
  input logic [1:0]      subLenCode,
  input logic            advance,
  input logic [VL_W+1:0] srcOfs,
  input logic [VL_W+1:0] dstOfs,
  input logic            pairValid,
  input logic            seqDone
);

  logic [VL_W+2:0] totalQ;
  logic            unitSubQ;
  logic            seenStartQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      totalQ     <= '0;
      unitSubQ   <= 1'b0;
      seenStartQ <= 1'b0;
    end else if (start) begin
      totalQ     <= (VL_W+3)'(vecLen) * (VL_W+3)'({1'b0, subLenCode} + 3'd1);
      unitSubQ   <= (subLenCode == 2'd0);
      seenStartQ <= 1'b1;
    end
  end

  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seenStartQ |-> (!pairValid && !seqDone));

  assert_first_pair_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vecLen != '0) |=> (pairValid && srcOfs == '0 && dstOfs == '0));

  assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pairValid |-> ((VL_W+3)'(srcOfs) < totalQ && (VL_W+3)'(dstOfs) < totalQ));

  assert_hold_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pairValid && !advance && !start) |=> (pairValid && $stable(srcOfs) && $stable(dstOfs)));

  assert_valid_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pairValid && seqDone));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seqDone && !start) |=> seqDone);

  assert_empty_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vecLen == '0) |=> (seqDone && !pairValid));

  assert_unit_sub_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pairValid && unitSubQ) |-> (srcOfs == dstOfs));

endmodule

bind subvec_xpose_seq subvec_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .vecLen     (vecLen),
  .subLenCode (subLenCode),
  .advance    (advance),
  .srcOfs     (srcOfs),
  .dstOfs     (dstOfs),
  .pairValid  (pairValid),
  .seqDone    (seqDone)
);

// File: tb/subvec_xpose_seq_tb.sv
module subvec_xpose_seq_tb;

  localparam int VL_W = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [VL_W-1:0] vecLen = '0;
  logic [1:0]      subLenCode = '0;
  logic            packEn = 1'b0;
  logic            unpackEn = 1'b0;
  logic            advance = 1'b0;
  logic [VL_W+1:0] srcOfs, dstOfs;
  logic            pairValid, seqDone;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit modelOn = 1'b0;

  // reference model state
  int  mVl = 0, mSub = 1, mStep = 0;
  bit  mPack = 0, mUnpack = 0, mValid = 0, mDone = 0;

  always #5 clk = ~clk;

  subvec_xpose_seq #(.VL_W(VL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen),
    .subLenCode(subLenCode), .packEn(packEn), .unpackEn(unpackEn),
    .advance(advance), .srcOfs(srcOfs), .dstOfs(dstOfs),
    .pairValid(pairValid), .seqDone(seqDone)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural model: step count k, i = k / SUB, j = k % SUB
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mValid = 0; mDone = 0; mStep = 0;
    end else if (start) begin
      mVl = int'(vecLen); mSub = int'(subLenCode) + 1;   // R12 code+1
      mPack = packEn; mUnpack = unpackEn; mStep = 0;
      mValid = (mVl != 0); mDone = (mVl == 0);
    end else if (mValid && advance) begin
      mStep++;
      if (mStep == mVl * mSub) begin mValid = 0; mDone = 1; end
    end
  end

  function automatic int linOf(int k); return k; endfunction
  function automatic int trOf(int k, int vl, int sub);
    return (k % sub) * vl + (k / sub);
  endfunction

  always @(negedge clk) begin
    if (modelOn) begin
      chk({curReq, " valid"}, int'(pairValid), int'(mValid));
      chk({curReq, " done"},  int'(seqDone),   int'(mDone));
      if (mValid) begin
        chk({curReq, " src"}, int'(srcOfs), mPack   ? trOf(mStep, mVl, mSub) : linOf(mStep));
        chk({curReq, " dst"}, int'(dstOfs), mUnpack ? trOf(mStep, mVl, mSub) : linOf(mStep));
      end
    end
  end

  task automatic kick(int vl, int code, bit pk, bit up);
    @(negedge clk);
    start = 1'b1; vecLen = VL_W'(vl); subLenCode = 2'(code);
    packEn = pk; unpackEn = up; advance = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // mode 0: advance every cycle, 1: every third cycle, 2: random
  task automatic drain(int mode);
    for (int c = 0; c < 2000; c++) begin
      if (seqDone) break;
      case (mode)
        0: advance = 1'b1;
        1: advance = (c % 3 == 2);
        default: advance = 1'($urandom % 2);
      endcase
      @(negedge clk);
    end
    advance = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", int'(pairValid), 0);
    chk("R1 done",  int'(seqDone), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", int'(pairValid), 0);
    chk("R1 idle done",  int'(seqDone), 0);
    modelOn = 1'b1;

    // R4 / R3: literal transpose order for VL=3, SUB=2, pack only
    begin
      int srcSeen[$];
      int dstSeen[$];
      int expSrc[6] = '{0, 3, 1, 4, 2, 5};
      curReq = "R4";
      kick(3, 1, 1'b1, 1'b0);
      chk("R2 first valid", int'(pairValid), 1);
      for (int c = 0; c < 20; c++) begin
        if (seqDone) break;
        if (pairValid) begin srcSeen.push_back(int'(srcOfs)); dstSeen.push_back(int'(dstOfs)); end
        advance = 1'b1;
        @(negedge clk);
      end
      advance = 1'b0;
      chk("R8 pair count", srcSeen.size(), 6);
      for (int n = 0; n < 6 && n < srcSeen.size(); n++) begin
        chk("R4 literal src", srcSeen[n], expSrc[n]);
        chk("R3 linear dst",  dstSeen[n], n);
      end
    end

    // R8: done held over idle cycles
    curReq = "R8";
    repeat (4) @(negedge clk);
    chk("R8 done held", int'(seqDone), 1);

    // R5 + R7: unpack only with gaps in advance
    curReq = "R5"; kick(4, 2, 1'b0, 1'b1);
    curReq = "R7"; drain(1);

    // R6 + R12: both flags, SUB=4
    curReq = "R6"; kick(5, 3, 1'b1, 1'b1); drain(0);

    // R3: neither flag, SUB=3
    curReq = "R3"; kick(6, 2, 1'b0, 1'b0); drain(0);

    // R10: SUB=1 collapses both orders
    curReq = "R10"; kick(7, 0, 1'b1, 1'b0); drain(0);

    // R9: empty vector
    curReq = "R9"; kick(0, 3, 1'b1, 1'b1);
    chk("R9 no pair", int'(pairValid), 0);
    chk("R9 done", int'(seqDone), 1);

    // R11: restart mid-sequence with advance high in the start cycle
    curReq = "R11"; kick(9, 3, 1'b1, 1'b0);
    advance = 1'b1; repeat (7) @(negedge clk);
    start = 1'b1; vecLen = VL_W'(4); subLenCode = 2'd1; packEn = 1'b0; unpackEn = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    chk("R11 restart src", int'(srcOfs), 0);
    chk("R11 restart dst", int'(dstOfs), 0);
    chk("R11 restart valid", int'(pairValid), 1);
    drain(0);

    // R13: configuration changes after start are ignored
    curReq = "R13"; kick(5, 2, 1'b1, 1'b0);
    vecLen = VL_W'(1); subLenCode = 2'd0; packEn = 1'b0; unpackEn = 1'b1;
    drain(0);

    // R12: each subvector code with random advance
    for (int code = 0; code < 4; code++) begin
      curReq = "R12"; kick(63 - code * 7, code, code[0], code[1]);
      drain(2);
    end

    modelOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule